// File: doc/BRIEF.md
# Multi-Channel DMA Engine with Event Flags

This block moves words between addresses on behalf of several independent channels, using one memory request port it owns by itself. Each channel is armed with a source address, a destination address, an item count and a set of mode bits. Once armed, a channel asks for service in one of three ways: continuously (memory-to-memory), while its hardware request line is high, or once for each software trigger pulse. A peripheral side is a fixed address, reached by turning off address stepping on that side.

An arbiter picks one requesting channel per item using the channel's programmed priority. The engine then reads one word from the source and writes it to the destination. After each item the channel steps its addresses and counts down. Three sticky event flags per channel report half transfer, transfer complete and transfer error. Each flag can raise the channel's interrupt, and writing 1 to a flag clears it. In circular mode a channel reloads its count and start addresses at the end of each pass and keeps running. Otherwise it disarms itself.

Top module: `dma_engine`

## Requirements
- R1: After a synchronous active-low reset, every channel is inactive, every flag is 0, every interrupt is 0 and `mem_req` is 0.
- R2: One item is a read at the channel's current source address (`mem_req`=1, `mem_we`=0), then a write of the returned word to its current destination address (`mem_we`=1). Each request holds address and direction steady until `mem_ack` or `mem_err`.
- R3: An armed channel requests service always if its memory-to-memory bit is set, else while `hw_req` is high, else once per `sw_trig` pulse (one pulse moves exactly one item).
- R4: Among requesting channels the highest priority value wins, and among equal values the lowest channel number wins.
- R5: After each item the source and destination addresses each advance by one only if their increment bit is set; otherwise they stay fixed.
- R6: The half-transfer flag (flag bit 0) sets when the number of items moved in the current pass equals half the loaded count, rounded down, provided that half is at least 1.
- R7: The transfer-complete flag (flag bit 1) sets when the last item of a pass is written; a non-circular channel then becomes inactive.
- R8: In circular mode, completing a pass reloads the count and both start addresses and the channel stays active.
- R9: A `mem_err` during either phase sets the transfer-error flag (flag bit 2), abandons the item and makes the channel inactive.
- R10: A 1 in a bit of `flag_clr` clears that flag only; a flag set in the same cycle stays set.
- R11: `irq[i]` is high whenever any flag of channel i is set together with its enable bit in `cfg_ie` (bit 0 half, bit 1 complete, bit 2 error).
- R12: Arming a channel with a count of 0 leaves it inactive, and an inactive channel never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_arm | input | NCH | One-cycle pulse per channel: latch that channel's configuration and start it |
| cfg_circ | input | NCH | Circular mode per channel |
| cfg_m2m | input | NCH | Memory-to-memory (free-running request) per channel |
| cfg_sinc | input | NCH | Source address increment enable per channel |
| cfg_dinc | input | NCH | Destination address increment enable per channel |
| cfg_prio | input | NCH*PW | Priority per channel, larger is more urgent |
| cfg_src | input | NCH*AW | Start source address per channel |
| cfg_dst | input | NCH*AW | Start destination address per channel |
| cfg_cnt | input | NCH*CW | Items per pass per channel |
| cfg_ie | input | NCH*3 | Interrupt enables per channel (half, complete, error) |
| hw_req | input | NCH | Hardware request line per channel |
| sw_trig | input | NCH | Software trigger pulse per channel |
| flag_clr | input | NCH*3 | Write-1-to-clear pulses per channel flag |
| ch_active | output | NCH | Channel armed and not finished |
| flag_ht | output | NCH | Half-transfer flag per channel |
| flag_tc | output | NCH | Transfer-complete flag per channel |
| flag_te | output | NCH | Transfer-error flag per channel |
| irq | output | NCH | Interrupt per channel |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the pending request |
| mem_err | input | 1 | One-cycle error ending the pending request |

## Verification
The assertions take for granted that the memory side answers only while `mem_req` is high, never raises `mem_ack` and `mem_err` together, and gives exactly one one-cycle response per request. They also assume a channel is never re-armed in the cycle it completes an item. The bench memory answers one cycle after it sees a new request and signals an error only for a single chosen read address. Every re-arm in the stimulus is issued after that channel's requests have stopped and the bus has gone quiet.

// File: rtl/dma_pkg.sv
// Shared types and flag positions for the DMA engine.
// Assumes: no other package uses these names.
package dma_pkg;
    typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_t;
    localparam int FLG_HT = 0;
    localparam int FLG_TC = 1;
    localparam int FLG_TE = 2;
    localparam int NFLG   = 3;
endpackage

// File: rtl/dma_arbiter.sv
// Priority arbiter: grants the requesting channel with the largest priority,
// the lowest index winning ties. Purely combinational.
// Assumes: NCH >= 1; result used only while the mover is idle.
module dma_arbiter #(
    parameter int NCH = 4,
    parameter int PW  = 2
) (
    input  logic [NCH-1:0]    req,
    input  logic [NCH*PW-1:0] prio,
    output logic [NCH-1:0]    grant,
    output logic              any
);
    // Scan upward; a strictly larger priority replaces the current pick.
    always_comb begin
        logic [PW-1:0] best_p;
        grant  = '0;
        any    = 1'b0;
        best_p = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i] && (!any || prio[i*PW +: PW] > best_p)) begin
                grant  = '0;
                grant[i] = 1'b1;
                best_p = prio[i*PW +: PW];
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_channel.sv
// One DMA channel: latches its configuration on arm, forms its request,
// steps addresses and count per finished item, keeps sticky event flags.
// Assumes: arm never coincides with done or err_hit for this channel.
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 8,
    parameter int PW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            circ,
    input  logic            m2m,
    input  logic            sinc,
    input  logic            dinc,
    input  logic [PW-1:0]   prio,
    input  logic [AW-1:0]   src,
    input  logic [AW-1:0]   dst,
    input  logic [CW-1:0]   cnt,
    input  logic [NFLG-1:0] ie,
    input  logic            hw_req,
    input  logic            sw_trig,
    input  logic [NFLG-1:0] clr,
    input  logic            grant,
    input  logic            done,
    input  logic            err_hit,
    output logic            req,
    output logic            active,
    output logic [PW-1:0]   prio_q,
    output logic [AW-1:0]   src_q,
    output logic [AW-1:0]   dst_q,
    output logic [NFLG-1:0] flags,
    output logic            irq
);
    logic [AW-1:0] src_b, dst_b;
    logic [CW-1:0] cnt_ld, rem_q, rem_nx;
    logic          circ_q, m2m_q, sinc_q, dinc_q, pend_q;
    logic          half_hit;
    logic [NFLG-1:0] set_v;

    assign rem_nx   = rem_q - CW'(1);
    assign half_hit = (cnt_ld > CW'(1)) && (rem_nx == cnt_ld - (cnt_ld >> 1));
    assign req      = active && (m2m_q || hw_req || pend_q);
    assign irq      = |(flags & ie);

    always_comb begin
        set_v = '0;
        set_v[FLG_HT] = done && half_hit;
        set_v[FLG_TC] = done && (rem_nx == '0);
        set_v[FLG_TE] = err_hit;
    end

    // Configuration latch, request pending bit, address and count progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; pend_q <= 1'b0;
            circ_q <= 1'b0; m2m_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
            prio_q <= '0; src_b <= '0; dst_b <= '0; src_q <= '0; dst_q <= '0;
            cnt_ld <= '0; rem_q <= '0;
        end else if (arm) begin
            active <= (cnt != '0); pend_q <= 1'b0;
            circ_q <= circ; m2m_q <= m2m; sinc_q <= sinc; dinc_q <= dinc;
            prio_q <= prio; src_b <= src; dst_b <= dst; src_q <= src; dst_q <= dst;
            cnt_ld <= cnt; rem_q <= cnt;
        end else begin
            pend_q <= (pend_q && !grant) || (sw_trig && active);
            if (err_hit) begin
                active <= 1'b0;
            end else if (done) begin
                if (rem_nx == '0) begin
                    if (circ_q) begin
                        src_q <= src_b; dst_q <= dst_b; rem_q <= cnt_ld;
                    end else begin
                        active <= 1'b0; rem_q <= rem_nx;
                    end
                end else begin
                    src_q <= src_q + AW'(sinc_q);
                    dst_q <= dst_q + AW'(dinc_q);
                    rem_q <= rem_nx;
                end
            end
        end
    end

    // Sticky flags: set has precedence over write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_v;
    end

    // R7
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !circ_q && rem_q == CW'(1)) |=> !active);
    // R8
    circ_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && circ_q && rem_q == CW'(1)) |=> (active && rem_q == cnt_ld));
    // R9
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_hit |=> (!active && flags[FLG_TE]));
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !arm) |=> !active);
endmodule

// File: rtl/dma_mover.sv
// Single-item mover: takes a grant, reads the source word, writes it to the
// destination, then reports done or error for the selected channel.
// Assumes: memory answers with one-cycle ack or err, never both, only while req.
module dma_mover
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           any_req,
    input  logic [NCH-1:0] grant,
    input  logic [AW-1:0]  rd_addr,
    input  logic [AW-1:0]  wr_addr,
    output logic [NCH-1:0] cur,
    output logic           take,
    output logic           done,
    output logic           err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    input  logic           mem_err
);
    mv_state_t     st;
    logic [DW-1:0] data_q;

    assign take      = (st == MV_IDLE) && any_req;
    assign done      = (st == MV_WRITE) && mem_ack && !mem_err;
    assign err       = (st != MV_IDLE) && mem_err;
    assign mem_req   = (st != MV_IDLE);
    assign mem_we    = (st == MV_WRITE);
    assign mem_addr  = (st == MV_WRITE) ? wr_addr : rd_addr;
    assign mem_wdata = data_q;

    // Phase sequencing and capture of the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= MV_IDLE; cur <= '0; data_q <= '0;
        end else begin
            case (st)
                MV_IDLE:  if (any_req) begin st <= MV_READ; cur <= grant; end
                MV_READ:  if (mem_err) st <= MV_IDLE;
                          else if (mem_ack) begin data_q <= mem_rdata; st <= MV_WRITE; end
                MV_WRITE: if (mem_err || mem_ack) st <= MV_IDLE;
                default:  st <= MV_IDLE;
            endcase
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R2
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_we)) |-> $past(mem_ack));
endmodule

// File: rtl/dma_engine.sv
// Top of the DMA engine: NCH channels, a priority arbiter and one mover
// sharing a single memory request port.
// Assumes: flattened per-channel configuration vectors, channel i at slice i.
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int CW  = 8,
    parameter int PW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    cfg_arm,
    input  logic [NCH-1:0]    cfg_circ,
    input  logic [NCH-1:0]    cfg_m2m,
    input  logic [NCH-1:0]    cfg_sinc,
    input  logic [NCH-1:0]    cfg_dinc,
    input  logic [NCH*PW-1:0] cfg_prio,
    input  logic [NCH*AW-1:0] cfg_src,
    input  logic [NCH*AW-1:0] cfg_dst,
    input  logic [NCH*CW-1:0] cfg_cnt,
    input  logic [NCH*3-1:0]  cfg_ie,
    input  logic [NCH-1:0]    hw_req,
    input  logic [NCH-1:0]    sw_trig,
    input  logic [NCH*3-1:0]  flag_clr,
    output logic [NCH-1:0]    ch_active,
    output logic [NCH-1:0]    flag_ht,
    output logic [NCH-1:0]    flag_tc,
    output logic [NCH-1:0]    flag_te,
    output logic [NCH-1:0]    irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err
);
    logic [NCH-1:0]    ch_req, grant, cur;
    logic [NCH*PW-1:0] prio_all;
    logic [NCH*AW-1:0] src_all, dst_all;
    logic              any_req, take, done, err;
    logic [AW-1:0]     rd_addr, wr_addr;
    logic [PW-1:0]     win_prio;

    dma_arbiter #(.NCH(NCH), .PW(PW)) u_arb (
        .req(ch_req), .prio(prio_all), .grant(grant), .any(any_req));

    dma_mover #(.NCH(NCH), .AW(AW), .DW(DW)) u_mv (
        .clk(clk), .rst_n(rst_n), .any_req(any_req), .grant(grant),
        .rd_addr(rd_addr), .wr_addr(wr_addr), .cur(cur), .take(take),
        .done(done), .err(err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [NFLG-1:0] fl;
        dma_channel #(.AW(AW), .CW(CW), .PW(PW)) u_ch (
            .clk(clk), .rst_n(rst_n), .arm(cfg_arm[i]), .circ(cfg_circ[i]),
            .m2m(cfg_m2m[i]), .sinc(cfg_sinc[i]), .dinc(cfg_dinc[i]),
            .prio(cfg_prio[i*PW +: PW]), .src(cfg_src[i*AW +: AW]),
            .dst(cfg_dst[i*AW +: AW]), .cnt(cfg_cnt[i*CW +: CW]),
            .ie(cfg_ie[i*NFLG +: NFLG]), .hw_req(hw_req[i]), .sw_trig(sw_trig[i]),
            .clr(flag_clr[i*NFLG +: NFLG]), .grant(grant[i] && take),
            .done(cur[i] && done), .err_hit(cur[i] && err),
            .req(ch_req[i]), .active(ch_active[i]), .prio_q(prio_all[i*PW +: PW]),
            .src_q(src_all[i*AW +: AW]), .dst_q(dst_all[i*AW +: AW]),
            .flags(fl), .irq(irq[i]));
        assign flag_ht[i] = fl[FLG_HT];
        assign flag_tc[i] = fl[FLG_TC];
        assign flag_te[i] = fl[FLG_TE];
    end

    // Select the addresses and priority of the channel in service or granted.
    always_comb begin
        rd_addr = '0; wr_addr = '0; win_prio = '0;
        for (int i = 0; i < NCH; i++) begin
            if (cur[i]) begin
                rd_addr |= src_all[i*AW +: AW];
                wr_addr |= dst_all[i*AW +: AW];
            end
            if (grant[i]) win_prio |= prio_all[i*PW +: PW];
        end
    end

    // R4
    grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ($onehot(grant) && |(grant & ch_req)));
    for (genvar j = 0; j < NCH; j++) begin : g_pchk
        // R4
        prio_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take && ch_req[j]) |-> (win_prio >= prio_all[j*PW +: PW]));
    end
endmodule

// File: tb/tb_dma_engine.sv
// Bench: behavioural per-clock reference model plus directed scenarios.
module tb_dma_engine;
    localparam int NCH = 4, AW = 8, DW = 16, CW = 8, PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NCH-1:0]    cfg_arm = '0, cfg_circ = '0, cfg_m2m = '0, cfg_sinc = '0, cfg_dinc = '0;
    logic [NCH*PW-1:0] cfg_prio = '0;
    logic [NCH*AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [NCH*CW-1:0] cfg_cnt = '0;
    logic [NCH*3-1:0]  cfg_ie = '0, flag_clr = '0;
    logic [NCH-1:0]    hw_req = '0, sw_trig = '0;
    logic [NCH-1:0]    ch_active, flag_ht, flag_tc, flag_te, irq;
    logic              mem_req, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic [DW-1:0]     mem_rdata = '0;
    logic              mem_ack = 1'b0, mem_err = 1'b0;

    dma_engine #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .PW(PW)) dut (.*);

    int n_chk = 0, n_fail = 0;
    int err_addr = -1;
    logic [DW-1:0] bmem [256];

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bench memory: responds one cycle after a fresh request.
    initial for (int a = 0; a < 256; a++) bmem[a] = pat(a);
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        if (mem_req && !mem_ack && !mem_err) begin
            if (!mem_we && int'(mem_addr) == err_addr) mem_err <= 1'b1;
            else begin
                mem_ack <= 1'b1;
                mem_rdata <= bmem[mem_addr];
                if (mem_we) bmem[mem_addr] <= mem_wdata;
            end
        end
    end

    // Reference model state (values the design holds during the current cycle).
    int m_act[NCH], m_src[NCH], m_dst[NCH], m_sb[NCH], m_db[NCH], m_rem[NCH], m_ld[NCH];
    int m_circ[NCH], m_m2m[NCH], m_si[NCH], m_di[NCH], m_prio[NCH], m_pend[NCH], m_fl[NCH];
    int m_st, m_cur, m_data;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cur = 0; m_data = 0;
            for (int i = 0; i < NCH; i++) begin
                m_act[i] = 0; m_src[i] = 0; m_dst[i] = 0; m_sb[i] = 0; m_db[i] = 0;
                m_rem[i] = 0; m_ld[i] = 0; m_circ[i] = 0; m_m2m[i] = 0; m_si[i] = 0;
                m_di[i] = 0; m_prio[i] = 0; m_pend[i] = 0; m_fl[i] = 0;
            end
        end else begin
            int grant, done, errc, st_n;
            // Compare every output with the model.
            for (int i = 0; i < NCH; i++) begin
                int iem;
                iem = int'(cfg_ie[i*3 +: 3]);
                chk(int'(ch_active[i]) == m_act[i], "R7 active", int'(ch_active[i]), m_act[i]);
                chk(int'(flag_ht[i]) == (m_fl[i] & 1), "R6 half flag", int'(flag_ht[i]), m_fl[i] & 1);
                chk(int'(flag_tc[i]) == ((m_fl[i] >> 1) & 1), "R7 complete flag", int'(flag_tc[i]), (m_fl[i] >> 1) & 1);
                chk(int'(flag_te[i]) == ((m_fl[i] >> 2) & 1), "R9 error flag", int'(flag_te[i]), (m_fl[i] >> 2) & 1);
                chk(int'(irq[i]) == int'((m_fl[i] & iem) != 0), "R11 irq", int'(irq[i]), int'((m_fl[i] & iem) != 0));
            end
            chk(int'(mem_req) == int'(m_st != 0), "R2 mem_req", int'(mem_req), int'(m_st != 0));
            if (m_st == 1) begin
                chk(mem_we == 1'b0, "R2 read phase we", int'(mem_we), 0);
                chk(int'(mem_addr) == m_src[m_cur], "R2 R5 read addr", int'(mem_addr), m_src[m_cur]);
            end else if (m_st == 2) begin
                chk(mem_we == 1'b1, "R2 write phase we", int'(mem_we), 1);
                chk(int'(mem_addr) == m_dst[m_cur], "R2 R5 write addr", int'(mem_addr), m_dst[m_cur]);
                chk(int'(mem_wdata) == m_data, "R2 write data", int'(mem_wdata), m_data);
            end
            // Advance the model by one clock.
            grant = -1; done = -1; errc = -1; st_n = m_st;
            if (m_st == 0)
                for (int i = 0; i < NCH; i++)
                    if (m_act[i] != 0 && (m_m2m[i] != 0 || hw_req[i] || m_pend[i] != 0))
                        if (grant < 0 || m_prio[i] > m_prio[grant]) grant = i;
            case (m_st)
                0: if (grant >= 0) begin st_n = 1; m_cur = grant; end
                1: if (mem_err) begin errc = m_cur; st_n = 0; end
                   else if (mem_ack) begin m_data = int'(mem_rdata); st_n = 2; end
                default: if (mem_err) begin errc = m_cur; st_n = 0; end
                   else if (mem_ack) begin done = m_cur; st_n = 0; end
            endcase
            m_st = st_n;
            for (int i = 0; i < NCH; i++) begin
                int setv, rn;
                setv = 0;
                rn = (m_rem[i] + 255) % 256;
                if (done == i && m_ld[i] > 1 && rn == m_ld[i] - m_ld[i] / 2) setv |= 1;
                if (done == i && rn == 0) setv |= 2;
                if (errc == i) setv |= 4;
                if (cfg_arm[i]) begin
                    m_ld[i] = int'(cfg_cnt[i*CW +: CW]); m_rem[i] = m_ld[i];
                    m_act[i] = int'(m_ld[i] != 0); m_pend[i] = 0;
                    m_src[i] = int'(cfg_src[i*AW +: AW]); m_sb[i] = m_src[i];
                    m_dst[i] = int'(cfg_dst[i*AW +: AW]); m_db[i] = m_dst[i];
                    m_circ[i] = int'(cfg_circ[i]); m_m2m[i] = int'(cfg_m2m[i]);
                    m_si[i] = int'(cfg_sinc[i]); m_di[i] = int'(cfg_dinc[i]);
                    m_prio[i] = int'(cfg_prio[i*PW +: PW]);
                end else begin
                    int act_old;
                    act_old = m_act[i];
                    m_pend[i] = int'((m_pend[i] != 0 && grant != i) || (sw_trig[i] && act_old != 0));
                    if (errc == i) m_act[i] = 0;
                    else if (done == i) begin
                        if (rn == 0) begin
                            if (m_circ[i] != 0) begin
                                m_src[i] = m_sb[i]; m_dst[i] = m_db[i]; m_rem[i] = m_ld[i];
                            end else begin
                                m_act[i] = 0; m_rem[i] = 0;
                            end
                        end else begin
                            m_src[i] = (m_src[i] + m_si[i]) % 256;
                            m_dst[i] = (m_dst[i] + m_di[i]) % 256;
                            m_rem[i] = rn;
                        end
                    end
                end
                m_fl[i] = (m_fl[i] & ~int'(flag_clr[i*3 +: 3])) | setv;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic setcfg(input int ch, input int s, input int d, input int c, input bit circ,
                          input bit m2m, input bit si, input bit di, input int pr, input int ie);
        cfg_src[ch*AW +: AW] = AW'(s); cfg_dst[ch*AW +: AW] = AW'(d);
        cfg_cnt[ch*CW +: CW] = CW'(c); cfg_circ[ch] = circ; cfg_m2m[ch] = m2m;
        cfg_sinc[ch] = si; cfg_dinc[ch] = di; cfg_prio[ch*PW +: PW] = PW'(pr);
        cfg_ie[ch*3 +: 3] = 3'(ie);
    endtask

    task automatic arm(input logic [NCH-1:0] m);
        tick(1); cfg_arm = m; tick(1); cfg_arm = '0;
    endtask

    task automatic clear(input int ch, input int bits);
        tick(1); flag_clr[ch*3 +: 3] = 3'(bits); tick(1); flag_clr = '0;
    endtask

    task automatic wait_off(input int ch);
        for (int k = 0; k < 400 && ch_active[ch]; k++) tick(1);
        tick(3);
    endtask

    task automatic first_read(input int exp, input string tag);
        int k;
        k = 0;
        while (!mem_req && k < 50) begin @(negedge clk); k++; end
        @(negedge clk);
        chk(int'(mem_addr) == exp, tag, int'(mem_addr), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(4); rst_n = 1'b1; tick(1);
        // R1: reset state
        @(negedge clk);
        chk(ch_active == '0, "R1 active after reset", int'(ch_active), 0);
        chk(flag_tc == '0 && flag_ht == '0 && flag_te == '0, "R1 flags after reset", int'(flag_tc), 0);
        chk(irq == '0, "R1 irq after reset", int'(irq), 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", int'(mem_req), 0);

        // R2 R6 R7 R11: memory-to-memory, four items
        setcfg(0, 'h10, 'h80, 4, 0, 1, 1, 1, 0, 3);
        arm(4'b0001); wait_off(0);
        chk(flag_ht[0] == 1'b1, "R6 half after 4 items", int'(flag_ht[0]), 1);
        chk(flag_tc[0] == 1'b1, "R7 complete after 4 items", int'(flag_tc[0]), 1);
        chk(irq[0] == 1'b1, "R11 irq with enables", int'(irq[0]), 1);
        for (int k = 0; k < 4; k++)
            chk(bmem['h80 + k] == pat('h10 + k), "R2 copied word", int'(bmem['h80 + k]), int'(pat('h10 + k)));
        clear(0, 1); @(negedge clk);
        chk(flag_ht[0] == 1'b0 && flag_tc[0] == 1'b1, "R10 clear half only", int'({flag_ht[0], flag_tc[0]}), 1);
        cfg_ie[2:0] = 3'b001; @(negedge clk);
        chk(irq[0] == 1'b0, "R11 irq masked", int'(irq[0]), 0);
        clear(0, 2);

        // R3 R5: memory-to-peripheral, software triggered, fixed destination
        setcfg(2, 'h20, 'hF0, 2, 0, 0, 1, 0, 0, 0);
        arm(4'b0100); tick(5);
        chk(bmem['hF0] == pat('hF0), "R3 no move without trigger", int'(bmem['hF0]), int'(pat('hF0)));
        sw_trig[2] = 1'b1; tick(1); sw_trig[2] = 1'b0; tick(12);
        chk(ch_active[2] == 1'b1, "R3 one item per trigger", int'(ch_active[2]), 1);
        chk(bmem['hF0] == pat('h20), "R3 first triggered item", int'(bmem['hF0]), int'(pat('h20)));
        sw_trig[2] = 1'b1; tick(1); sw_trig[2] = 1'b0; tick(12);
        chk(ch_active[2] == 1'b0, "R7 done after two triggers", int'(ch_active[2]), 0);
        chk(bmem['hF0] == pat('h21), "R5 fixed destination", int'(bmem['hF0]), int'(pat('h21)));
        clear(2, 7);

        // R3 R5: peripheral-to-memory on the hardware request line, fixed source
        setcfg(1, 'h05, 'h90, 3, 0, 0, 0, 1, 0, 0);
        arm(4'b0010); hw_req[1] = 1'b1; wait_off(1); hw_req[1] = 1'b0;
        for (int k = 0; k < 3; k++)
            chk(bmem['h90 + k] == pat('h05), "R5 fixed source", int'(bmem['h90 + k]), int'(pat('h05)));
        clear(1, 7);

        // R4: equal priority, lower channel first
        setcfg(2, 'h30, 'hA0, 2, 0, 1, 1, 1, 1, 0);
        setcfg(3, 'h40, 'hB0, 2, 0, 1, 1, 1, 1, 0);
        arm(4'b1100); first_read('h30, "R4 tie goes to lower channel");
        wait_off(2); wait_off(3); clear(2, 7); clear(3, 7);
        // R4: higher priority value wins over lower channel number
        setcfg(0, 'h50, 'hC0, 1, 0, 1, 1, 1, 0, 0);
        setcfg(1, 'h60, 'hD0, 1, 0, 1, 1, 1, 3, 0);
        arm(4'b0011); first_read('h60, "R4 higher priority first");
        wait_off(0); wait_off(1); clear(0, 7); clear(1, 7);

        // R8 R12: circular reload on the hardware request line
        setcfg(3, 'h70, 'hE0, 2, 1, 0, 1, 1, 0, 0);
        arm(4'b1000); hw_req[3] = 1'b1; tick(30); hw_req[3] = 1'b0; tick(12);
        chk(ch_active[3] == 1'b1, "R8 still active after passes", int'(ch_active[3]), 1);
        chk(flag_tc[3] == 1'b1, "R8 complete flag per pass", int'(flag_tc[3]), 1);
        chk(bmem['hE0] == pat('h70) && bmem['hE1] == pat('h71), "R8 reload of addresses", int'(bmem['hE1]), int'(pat('h71)));
        chk(bmem['hE2] == pat('hE2), "R8 no run past the count", int'(bmem['hE2]), int'(pat('hE2)));
        setcfg(3, 'h70, 'hE0, 0, 0, 1, 1, 1, 0, 0);
        arm(4'b1000); tick(8);
        chk(ch_active[3] == 1'b0, "R12 zero count stays inactive", int'(ch_active[3]), 0);
        chk(mem_req == 1'b0, "R12 no request when inactive", int'(mem_req), 0);
        clear(3, 7);

        // R9 R10: error on the second read
        err_addr = 'h12;
        setcfg(1, 'h11, 'h88, 4, 0, 1, 1, 1, 0, 4);
        arm(4'b0010); wait_off(1);
        chk(flag_te[1] == 1'b1, "R9 error flag", int'(flag_te[1]), 1);
        chk(flag_tc[1] == 1'b0, "R9 no completion on error", int'(flag_tc[1]), 0);
        chk(irq[1] == 1'b1, "R11 error irq", int'(irq[1]), 1);
        chk(bmem['h89] == pat('h89), "R9 failed item not written", int'(bmem['h89]), int'(pat('h89)));
        chk(bmem['h88] == pat('h11), "R9 earlier item kept", int'(bmem['h88]), int'(pat('h11)));
        clear(1, 4); @(negedge clk);
        chk(flag_te[1] == 1'b0, "R10 error flag cleared", int'(flag_te[1]), 0);
        err_addr = -1;

        tick(4);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule